// File: doc/BRIEF.md
# End-of-Write Status Responder

This block sits on the read path of a page-programmable nonvolatile memory. While the internal program or erase cycle runs, it replaces what the array returns with progress information, so that software can poll the bus to find out when the device is ready again. When a cycle is launched, the block captures the address and byte that were loaded last, and whether the cycle is a whole-array erase. The top bit of a status read is the inverse of the captured byte's top bit. The next bit toggles on every status read and starts at 1 after each launch.

Once the busy flag drops, reads return array contents unchanged. The top bit then matches the true data and the toggle bit stops changing, which tells software that the cycle is over. During an erase only the toggle bit carries meaning. The block drives 0 on every other bit so that the output is deterministic. Read results are registered and appear one clock after the read strobe.

Top module: `eow_status_resp`

## Requirements
- R1: After reset, rdData is all zeros and rdValid is 0.
- R2: A read strobe (rdEn high at a clock edge) raises rdValid for exactly the next cycle. rdData changes only in that cycle and otherwise holds its value.
- R3: When busyIn and startIn are both low, a read returns arrayData from the strobe cycle without change.
- R4: During a program cycle, bit 7 of every status read is the inverse of bit 7 of the captured byte. On a read of the captured address, bits 5..0 carry the captured byte's bits 5..0. On any other address these bits are 0.
- R5: A launch (startIn high) captures lastAddr, lastData and eraseIn at that edge. A read in the same cycle as the launch already sees the new capture.
- R6: Successive status reads within one cycle return bit 6 inverted relative to the previous status read.
- R7: The first status read after a launch returns bit 6 = 1. This also holds when a launch occurs while a cycle is still running, and when the read occurs in the same cycle as the launch.
- R8: During an erase cycle, bit 7 and bits 5..0 of a status read are 0 and bit 6 toggles as in R6.
- R9: Once busyIn drops, reads return true array data. Bit 6 no longer alternates across consecutive reads of unchanged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle pulse launching an internal cycle |
| eraseIn | input | 1 | Launch is a whole-array erase when high |
| busyIn | input | 1 | Internal cycle in progress (from the write timer) |
| lastAddr | input | ADDR_W | Address of the byte loaded last |
| lastData | input | DATA_W | Byte loaded last |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| arrayData | input | DATA_W | Array read data for rdAddr |
| rdData | output | DATA_W | Registered read result |
| rdValid | output | 1 | rdData was updated by a read this cycle |

## Verification
The hardest situations to reach are the ones where a launch and a status read interact. One is a read in the very cycle of a launch. Another is a second launch issued while the first cycle is still busy: the toggle must restart at 1 and the captured byte must be replaced. The bench reaches both with directed sequences, and its random phase relaunches mid-cycle and mixes erase and program launches. Reads go both to the captured address and to other addresses, so that the address-match path of the polling bits is exercised in both directions.

// File: rtl/eow_status_pkg.sv
package eow_status_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic capture;     // latch last address/data this cycle
    logic statusRead;  // this read returns the status word
    logic passRead;    // this read returns array data
    logic toggleVal;   // toggle bit value for this read
    logic eraseMode;   // effective erase flag for this read
  } statStrobe_t;

endpackage

// File: rtl/eow_status_ctrl.sv
module eow_status_ctrl
  import eow_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        eraseIn,
  input  logic        busyIn,
  input  logic        rdEn,
  output statStrobe_t strobe
);

  logic tglQ;
  logic eraseQ;
  logic cycleOn;

  // A launch counts as busy from its own edge
  assign cycleOn = busyIn | startIn;

  always_comb begin
    strobe.capture    = startIn;
    strobe.statusRead = rdEn & cycleOn;
    strobe.passRead   = rdEn & ~cycleOn;
    strobe.toggleVal  = startIn ? 1'b1 : tglQ;
    strobe.eraseMode  = startIn ? eraseIn : eraseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tglQ   <= 1'b1;
      eraseQ <= 1'b0;
    end else begin
      if (startIn) begin
        eraseQ <= eraseIn;
      end
      if (startIn || strobe.statusRead) begin
        tglQ <= strobe.statusRead ? ~strobe.toggleVal : strobe.toggleVal;
      end
    end
  end

endmodule

// File: rtl/eow_status_dp.sv
module eow_status_dp
  import eow_status_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic [DATA_W-1:0] lastData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int POLL_POS = DATA_W - 1;
  localparam int TGL_POS  = DATA_W - 2;
  localparam int LOW_W    = DATA_W - 2;

  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] effData;
  logic [DATA_W-1:0] statusWord;

  // Bypass so a read in the launch cycle sees the new capture
  assign effAddr = strobe.capture ? lastAddr : capAddr;
  assign effData = strobe.capture ? lastData : capData;

  always_comb begin
    statusWord = '0;
    if (!strobe.eraseMode) begin
      statusWord[POLL_POS] = ~effData[POLL_POS];
      if (rdAddr == effAddr) begin
        statusWord[LOW_W-1:0] = effData[LOW_W-1:0];
      end
    end
    statusWord[TGL_POS] = strobe.toggleVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
    end else if (strobe.capture) begin
      capAddr <= lastAddr;
      capData <= lastData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.statusRead | strobe.passRead;
      if (strobe.statusRead) begin
        rdData <= statusWord;
      end else if (strobe.passRead) begin
        rdData <= arrayData;
      end
    end
  end

endmodule

// File: rtl/eow_status_resp.sv
module eow_status_resp
  import eow_status_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              eraseIn,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic [DATA_W-1:0] lastData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  statStrobe_t strobe;

  eow_status_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .eraseIn (eraseIn),
    .busyIn  (busyIn),
    .rdEn    (rdEn),
    .strobe  (strobe)
  );

  eow_status_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lastAddr  (lastAddr),
    .lastData  (lastData),
    .rdAddr    (rdAddr),
    .arrayData (arrayData),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/eow_status_resp_chk.sv
module eow_status_resp_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              eraseIn,
  input logic              busyIn,
  input logic [ADDR_W-1:0] lastAddr,
  input logic [DATA_W-1:0] lastData,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid
);

  localparam int P = DATA_W - 1;
  localparam int T = DATA_W - 2;
  localparam int L = DATA_W - 2;

  logic [ADDR_W-1:0] ckAddr;
  logic [DATA_W-1:0] ckData;
  logic              ckErase;
  logic              statD;
  logic              startD;
  logic              haveStat;
  logic              lastTgl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckAddr   <= '0;
      ckData   <= '0;
      ckErase  <= 1'b0;
      statD    <= 1'b0;
      startD   <= 1'b0;
      haveStat <= 1'b0;
      lastTgl  <= 1'b0;
    end else begin
      if (startIn) begin
        ckAddr  <= lastAddr;
        ckData  <= lastData;
        ckErase <= eraseIn;
      end
      statD  <= rdEn & (busyIn | startIn);
      startD <= startIn;
      if (startD) begin
        haveStat <= statD;
      end else if (statD) begin
        haveStat <= 1'b1;
      end
      if (statD) begin
        lastTgl <= rdData[T];
      end
    end
  end

  // R2
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (!rdValid && $stable(rdData)));

  // R3
  passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !busyIn && !startIn) |=> (rdData == $past(arrayData)));

  // R4
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busyIn && !startIn && !ckErase && rdAddr == ckAddr)
      |=> (rdData[P] != $past(ckData[P])));

  // R8
  erase_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busyIn && !startIn && ckErase)
      |=> (rdData[P] == 1'b0 && rdData[L-1:0] == '0));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statD && !startD && haveStat) |-> (rdData[T] != lastTgl));

  // R7
  first_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statD && (startD || !haveStat)) |-> rdData[T]);

endmodule

bind eow_status_resp eow_status_resp_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startIn   (startIn),
  .eraseIn   (eraseIn),
  .busyIn    (busyIn),
  .lastAddr  (lastAddr),
  .lastData  (lastData),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .arrayData (arrayData),
  .rdData    (rdData),
  .rdValid   (rdValid)
);

// File: tb/eow_status_resp_tb_top.sv
module eow_status_resp_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic          eraseIn = 1'b0;
  logic          busyIn = 1'b0;
  logic [AW-1:0] lastAddr = '0;
  logic [DW-1:0] lastData = '0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] arrayData = '0;
  logic [DW-1:0] rdData;
  logic          rdValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  logic          mBusy = 1'b0;
  logic          mTgl = 1'b1;
  logic [AW-1:0] mA = '0;
  logic [DW-1:0] mD = '0;
  logic          mE = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eow_status_resp #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .eraseIn   (eraseIn),
    .busyIn    (busyIn),
    .lastAddr  (lastAddr),
    .lastData  (lastData),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .arrayData (arrayData),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] statusWord(logic [AW-1:0] a);
    logic [DW-1:0] w = '0;
    if (!mE) begin
      w[7] = ~mD[7];
      if (a == mA) w[5:0] = mD[5:0];
    end
    w[6] = mTgl;
    return w;
  endfunction

  task automatic doRead(logic [AW-1:0] a, logic [DW-1:0] arr, string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a; arrayData = arr;
    if (mBusy) begin
      exp = statusWord(a);
      mTgl = ~mTgl;
    end else begin
      exp = arr;
    end
    @(negedge clk);
    rdEn = 1'b0;
    check({req, " valid"}, {7'd0, rdValid}, 8'd1);
    check(req, rdData, exp);
  endtask

  task automatic doStart(logic [AW-1:0] a, logic [DW-1:0] d, logic er,
                         bit withRead, logic [AW-1:0] ra, string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    startIn = 1'b1; busyIn = 1'b1; eraseIn = er; lastAddr = a; lastData = d;
    mBusy = 1'b1; mTgl = 1'b1; mA = a; mD = d; mE = er;
    exp = '0;
    if (withRead) begin
      rdEn = 1'b1; rdAddr = ra; arrayData = 8'hA5;
      exp = statusWord(ra);
      mTgl = ~mTgl;
    end
    @(negedge clk);
    startIn = 1'b0; rdEn = 1'b0;
    if (withRead) check(req, rdData, exp);
  endtask

  task automatic endBusy();
    @(negedge clk);
    busyIn = 1'b0; mBusy = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 data", rdData, 8'h00);
    check("R1 valid", {7'd0, rdValid}, 8'h00);
    rstN = 1'b1;

    // R3: passthrough while idle
    doRead(17'h00010, 8'h3C, "R3 idle a");
    doRead(17'h1FFFF, 8'hC3, "R3 idle b");

    // R2: output holds without a strobe
    held = rdData;
    @(negedge clk);
    @(negedge clk);
    check("R2 hold", rdData, held);
    check("R2 no valid", {7'd0, rdValid}, 8'h00);

    // R4 R5 R6 R7: program cycle, top bit set
    doStart(17'h00123, 8'hB5, 1'b0, 1'b0, '0, "R5");
    doRead(17'h00123, 8'h00, "R4 R7 first");
    doRead(17'h00123, 8'h00, "R6 second");
    doRead(17'h00077, 8'hFF, "R4 other addr");
    doRead(17'h00123, 8'h11, "R6 fourth");

    // R7: relaunch mid-cycle with read in launch cycle
    doStart(17'h00400, 8'h4A, 1'b0, 1'b1, 17'h00400, "R7 launch read");
    doRead(17'h00400, 8'h00, "R6 after launch read");

    // R8: erase cycle
    doStart(17'h00001, 8'h80, 1'b1, 1'b0, '0, "R8");
    doRead(17'h00001, 8'hFF, "R8 first");
    doRead(17'h00002, 8'hFF, "R8 second");
    doRead(17'h00001, 8'hFF, "R8 third");

    // R9: completion returns true data, no toggling
    endBusy();
    doRead(17'h00001, 8'h40, "R9 true a");
    doRead(17'h00001, 8'h40, "R9 true b");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      logic [AW-1:0] ra = ($urandom_range(0, 1) == 0) ? mA : AW'($urandom);
      if (op == 0) begin
        doStart(AW'($urandom), DW'($urandom), ($urandom_range(0, 3) == 0),
                1'b0, '0, "R5 rand");
      end else if (op == 1) begin
        doStart(AW'($urandom), DW'($urandom), ($urandom_range(0, 3) == 0),
                1'b1, ra, "R7 rand launch read");
      end else if (op == 2) begin
        endBusy();
      end else begin
        doRead(ra, DW'($urandom), "R4 R6 R8 R9 rand");
      end
    end

    endBusy();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule